// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This block records the current clock time when a timing event packet passes the MAC, and holds that time until software collects it. It has two independent capture channels, one for the transmit direction and one for the receive direction. Packet classification is done elsewhere. Each channel receives a one-cycle capture strobe and samples the free-running time input on that edge. A held capture locks its channel. No later strobe can overwrite it until the high word has been read, so every stored value belongs to exactly one packet. A strobe that arrives while the channel is locked is dropped and raises a sticky missed-event flag.

The block also has a per-packet receive mode. At the start of a frame, it latches the time and sends a four-dword prefix on a valid/ready stream, ahead of the frame bytes. Dwords 0 and 1 are zero. Dword 2 carries the low time word and dword 3 carries the high time word. Within each dword, the least-significant byte sits in `tdata[7:0]`, which is the byte that goes first in memory (little-endian).

Stream rules on the prefix port:
- A beat transfers on a rising edge where both valid and ready are high.
- While valid is high and ready is low, the data and the last flag hold still.
- The consumer may hold ready low for any number of cycles.

Top module: `ts_capture_top`

## Requirements
- R1: After reset, both channel valid flags are 0, both missed flags are 0, and the prefix stream's valid is 0.
- R2: When a channel's enable is 1, its valid is 0 and its strobe is 1 at a rising edge, the channel stores the time input from that edge. From the next cycle, valid is 1, the low output equals time bits 31:0 and the high output equals time bits 63:32.
- R3: While a channel's valid is 1, its capture words do not change and further strobes are dropped. Each dropped strobe sets that channel's missed flag.
- R4: A high-word read pulse while valid is 1 clears valid in the next cycle. A later strobe then captures a new time.
- R5: If a strobe and a high-word read reach a locked channel at the same edge, the read wins. Valid clears, the capture words keep the earlier value, and the missed flag is set.
- R6: While a channel's enable is 0, its valid is 0 from the next cycle on. Strobes are ignored, and they leave both the capture words and the missed flag untouched.
- R7: The missed flag stays 1 until a clear pulse. If a new drop and a clear fall at the same edge, the flag stays 1.
- R8: The transmit and receive channels are independent. Activity on one never changes the other's outputs.
- R9: In per-packet mode, a start pulse latches the time and emits four beats in order:

  | Beat | Data |
  |------|------|
  | 0 | 0 |
  | 1 | 0 |
  | 2 | time bits 31:0 |
  | 3 | time bits 63:32 |

  The byte carrying time bits 7:0 is in `tdata[7:0]`. Last is 1 on beat 3 only.
- R10: While the prefix valid is 1 and ready is 0, valid stays 1 and data and last stay unchanged. The prefix advances one beat per handshake only.
- R11: A start pulse is ignored while per-packet mode is 0 or while a prefix is still being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current clock time |
| tx_en | input | 1 | Transmit channel enable |
| tx_strobe | input | 1 | Transmit capture strobe |
| tx_hi_rd | input | 1 | Transmit high-word read pulse (releases lock) |
| tx_miss_clr | input | 1 | Clear transmit missed flag |
| tx_valid | output | 1 | Transmit capture held |
| tx_lo | output | 32 | Transmit capture, low word |
| tx_hi | output | 32 | Transmit capture, high word |
| tx_missed | output | 1 | Sticky transmit missed-event flag |
| rx_en | input | 1 | Receive channel enable |
| rx_strobe | input | 1 | Receive capture strobe |
| rx_hi_rd | input | 1 | Receive high-word read pulse (releases lock) |
| rx_miss_clr | input | 1 | Clear receive missed flag |
| rx_valid | output | 1 | Receive capture held |
| rx_lo | output | 32 | Receive capture, low word |
| rx_hi | output | 32 | Receive capture, high word |
| rx_missed | output | 1 | Sticky receive missed-event flag |
| pkt_mode | input | 1 | Per-packet prefix mode enable |
| pfx_start | input | 1 | Frame start pulse, latches time for prefix |
| pfx_tready | input | 1 | Prefix stream ready |
| pfx_tvalid | output | 1 | Prefix stream valid |
| pfx_tdata | output | 32 | Prefix dword, little-endian bytes |
| pfx_tlast | output | 1 | Final prefix dword |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 64-bit time and a four-dword prefix. With these values the two halves of a capture are distinct patterns, so a swapped or truncated word shows up directly. The prefix is short enough to step through beat by beat, with ready held low in the middle. That brings within reach the same-edge collisions between read and strobe, and between drop and clear. It also covers a start pulse that arrives while a prefix is stalled.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned PFX_DWORDS_DEF = 4;
  localparam int unsigned NUM_CHAN = 2;
  localparam int unsigned CH_TX = 0;
  localparam int unsigned CH_RX = 1;
endpackage

// File: rtl/ts_cap_chan.sv
module ts_cap_chan #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              strobe,
  input  logic [TIME_W-1:0] time_now,
  input  logic              hi_rd,
  input  logic              miss_clr,
  output logic              valid,
  output logic [WORD_W-1:0] cap_lo,
  output logic [WORD_W-1:0] cap_hi,
  output logic              missed
);
  logic [TIME_W-1:0] cap_q;
  logic              valid_q;
  logic              missed_q;
  logic              drop;

  // a strobe that finds the channel locked is lost
  assign drop = en && strobe && valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q   <= '0;
      valid_q <= 1'b0;
    end else if (!en) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (hi_rd) valid_q <= 1'b0;
    end else if (strobe) begin
      valid_q <= 1'b1;
      cap_q   <= time_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        missed_q <= 1'b0;
    else if (drop)     missed_q <= 1'b1;
    else if (miss_clr) missed_q <= 1'b0;
  end

  assign valid  = valid_q;
  assign missed = missed_q;
  assign cap_lo = cap_q[WORD_W-1:0];
  assign cap_hi = cap_q[TIME_W-1:WORD_W];

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> $stable(cap_q));
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid_q && hi_rd) |=> !valid_q);
  p_disabled_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid_q);
  p_missed_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_q && !miss_clr) |=> missed_q);
  p_drop_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && strobe && valid_q) |=> missed_q);
endmodule

// File: rtl/ts_prefix_gen.sv
module ts_prefix_gen #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DWORDS = 4,
  localparam int unsigned TIME_W = 2 * WORD_W,
  localparam int unsigned IDX_W = $clog2(DWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              start,
  input  logic [TIME_W-1:0] time_now,
  input  logic              tready,
  output logic              tvalid,
  output logic [WORD_W-1:0] tdata,
  output logic              tlast
);
  localparam logic [IDX_W-1:0] LO_IDX   = IDX_W'(DWORDS - 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DWORDS - 1);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TIME_W-1:0] stamp_q;
  logic              beat;

  assign beat = active_q && tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      stamp_q  <= '0;
    end else if (!active_q) begin
      if (mode && start) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        stamp_q  <= time_now;
      end
    end else if (beat) begin
      if (idx_q == LAST_IDX) active_q <= 1'b0;
      else                   idx_q    <= idx_q + 1'b1;
    end
  end

  // leading dwords are reserved zero, time words occupy the last two
  always_comb begin
    tdata = '0;
    if (idx_q == LO_IDX)        tdata = stamp_q[WORD_W-1:0];
    else if (idx_q == LAST_IDX) tdata = stamp_q[TIME_W-1:WORD_W];
  end

  assign tvalid = active_q;
  assign tlast  = active_q && (idx_q == LAST_IDX);

  p_backpressure_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));
  p_end_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && tlast) |=> !tvalid);
  p_stamp_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> $stable(stamp_q));
endmodule

// File: rtl/ts_capture_top.sv
module ts_capture_top
  import ts_cap_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned PFX_DWORDS = PFX_DWORDS_DEF,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              tx_en,
  input  logic              tx_strobe,
  input  logic              tx_hi_rd,
  input  logic              tx_miss_clr,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_lo,
  output logic [WORD_W-1:0] tx_hi,
  output logic              tx_missed,
  input  logic              rx_en,
  input  logic              rx_strobe,
  input  logic              rx_hi_rd,
  input  logic              rx_miss_clr,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_lo,
  output logic [WORD_W-1:0] rx_hi,
  output logic              rx_missed,
  input  logic              pkt_mode,
  input  logic              pfx_start,
  input  logic              pfx_tready,
  output logic              pfx_tvalid,
  output logic [WORD_W-1:0] pfx_tdata,
  output logic              pfx_tlast
);
  logic [NUM_CHAN-1:0] en_v, stb_v, rd_v, clr_v, val_v, mis_v;
  logic [WORD_W-1:0]   lo_v [NUM_CHAN];
  logic [WORD_W-1:0]   hi_v [NUM_CHAN];

  assign en_v[CH_TX]  = tx_en;
  assign en_v[CH_RX]  = rx_en;
  assign stb_v[CH_TX] = tx_strobe;
  assign stb_v[CH_RX] = rx_strobe;
  assign rd_v[CH_TX]  = tx_hi_rd;
  assign rd_v[CH_RX]  = rx_hi_rd;
  assign clr_v[CH_TX] = tx_miss_clr;
  assign clr_v[CH_RX] = rx_miss_clr;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    ts_cap_chan #(.WORD_W(WORD_W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_v[c]),
      .strobe   (stb_v[c]),
      .time_now (time_now),
      .hi_rd    (rd_v[c]),
      .miss_clr (clr_v[c]),
      .valid    (val_v[c]),
      .cap_lo   (lo_v[c]),
      .cap_hi   (hi_v[c]),
      .missed   (mis_v[c])
    );
  end

  assign tx_valid  = val_v[CH_TX];
  assign rx_valid  = val_v[CH_RX];
  assign tx_missed = mis_v[CH_TX];
  assign rx_missed = mis_v[CH_RX];
  assign tx_lo     = lo_v[CH_TX];
  assign tx_hi     = hi_v[CH_TX];
  assign rx_lo     = lo_v[CH_RX];
  assign rx_hi     = hi_v[CH_RX];

  ts_prefix_gen #(.WORD_W(WORD_W), .DWORDS(PFX_DWORDS)) pfx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (pkt_mode),
    .start    (pfx_start),
    .time_now (time_now),
    .tready   (pfx_tready),
    .tvalid   (pfx_tvalid),
    .tdata    (pfx_tdata),
    .tlast    (pfx_tlast)
  );

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_strobe && !tx_valid) |=> (tx_valid && ({tx_hi, tx_lo} == $past(time_now))));
  p_chan_isolation_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_valid) |=> !rx_valid);
endmodule

// File: tb/ts_capture_top_tb.sv
module ts_capture_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_now;
  logic        tx_en, tx_strobe, tx_hi_rd, tx_miss_clr;
  logic        rx_en, rx_strobe, rx_hi_rd, rx_miss_clr;
  logic        tx_valid, tx_missed, rx_valid, rx_missed;
  logic [31:0] tx_lo, tx_hi, rx_lo, rx_hi;
  logic        pkt_mode, pfx_start, pfx_tready;
  logic        pfx_tvalid, pfx_tlast;
  logic [31:0] pfx_tdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ts_capture_top dut_i (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .tx_en(tx_en), .tx_strobe(tx_strobe), .tx_hi_rd(tx_hi_rd), .tx_miss_clr(tx_miss_clr),
    .tx_valid(tx_valid), .tx_lo(tx_lo), .tx_hi(tx_hi), .tx_missed(tx_missed),
    .rx_en(rx_en), .rx_strobe(rx_strobe), .rx_hi_rd(rx_hi_rd), .rx_miss_clr(rx_miss_clr),
    .rx_valid(rx_valid), .rx_lo(rx_lo), .rx_hi(rx_hi), .rx_missed(rx_missed),
    .pkt_mode(pkt_mode), .pfx_start(pfx_start), .pfx_tready(pfx_tready),
    .pfx_tvalid(pfx_tvalid), .pfx_tdata(pfx_tdata), .pfx_tlast(pfx_tlast)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 tx_valid", 64'(tx_valid), 64'd0);
    chk("R1 rx_valid", 64'(rx_valid), 64'd0);
    chk("R1 missed", 64'({tx_missed, rx_missed}), 64'd0);
    chk("R1 pfx_tvalid", 64'(pfx_tvalid), 64'd0);
  endtask

  task automatic t_capture();
    tx_en = 1; time_now = 64'h1122_3344_5566_7788; tx_strobe = 1;
    step(); tx_strobe = 0; time_now = 64'hFFFF_0000_FFFF_0000;
    chk("R2 valid", 64'(tx_valid), 64'd1);
    chk("R2 lo", 64'(tx_lo), 64'h5566_7788);
    chk("R2 hi", 64'(tx_hi), 64'h1122_3344);
  endtask

  task automatic t_hold();
    tx_strobe = 1; time_now = 64'hDEAD_BEEF_0BAD_F00D;
    step(); tx_strobe = 0;
    chk("R3 words held", {tx_hi, tx_lo}, 64'h1122_3344_5566_7788);
    chk("R3 missed set", 64'(tx_missed), 64'd1);
    chk("R3 still valid", 64'(tx_valid), 64'd1);
  endtask

  task automatic t_release();
    tx_hi_rd = 1; step(); tx_hi_rd = 0;
    chk("R4 valid cleared", 64'(tx_valid), 64'd0);
    time_now = 64'h0000_0001_8000_0002; tx_strobe = 1; step(); tx_strobe = 0;
    chk("R4 recapture", {tx_hi, tx_lo}, 64'h0000_0001_8000_0002);
  endtask

  task automatic t_collide();
    tx_miss_clr = 1; step(); tx_miss_clr = 0;
    chk("R7 cleared", 64'(tx_missed), 64'd0);
    time_now = 64'h9999_8888_7777_6666; tx_strobe = 1; tx_hi_rd = 1;
    step(); tx_strobe = 0; tx_hi_rd = 0;
    chk("R5 valid clear", 64'(tx_valid), 64'd0);
    chk("R5 old words", {tx_hi, tx_lo}, 64'h0000_0001_8000_0002);
    chk("R5 missed", 64'(tx_missed), 64'd1);
  endtask

  task automatic t_miss_race();
    time_now = 64'h4444_0000_0000_4444; tx_strobe = 1; step(); tx_strobe = 0;
    tx_miss_clr = 1; step(); tx_miss_clr = 0;
    chk("R7 clear", 64'(tx_missed), 64'd0);
    step();
    chk("R7 stays clear", 64'(tx_missed), 64'd0);
    tx_strobe = 1; tx_miss_clr = 1; step(); tx_strobe = 0; tx_miss_clr = 0;
    chk("R7 set wins", 64'(tx_missed), 64'd1);
    step(); step();
    chk("R7 sticky", 64'(tx_missed), 64'd1);
  endtask

  task automatic t_disable();
    tx_en = 0; step();
    chk("R6 valid drop", 64'(tx_valid), 64'd0);
    tx_miss_clr = 1; step(); tx_miss_clr = 0;
    time_now = 64'hABAB_ABAB_CDCD_CDCD; tx_strobe = 1; step(); tx_strobe = 0;
    chk("R6 no capture", 64'(tx_valid), 64'd0);
    chk("R6 words kept", {tx_hi, tx_lo}, 64'h4444_0000_0000_4444);
    chk("R6 no missed", 64'(tx_missed), 64'd0);
  endtask

  task automatic t_indep();
    rx_en = 1; time_now = 64'h0F0F_1E1E_2D2D_3C3C; rx_strobe = 1; step(); rx_strobe = 0;
    chk("R8 rx capture", {rx_hi, rx_lo}, 64'h0F0F_1E1E_2D2D_3C3C);
    chk("R8 tx untouched", 64'({tx_valid, tx_missed}), 64'd0);
    tx_en = 1; time_now = 64'h7; tx_strobe = 1; rx_hi_rd = 1; step();
    tx_strobe = 0; rx_hi_rd = 0;
    chk("R8 tx words", {tx_hi, tx_lo}, 64'h7);
    chk("R8 rx released", 64'(rx_valid), 64'd0);
    chk("R8 rx words", {rx_hi, rx_lo}, 64'h0F0F_1E1E_2D2D_3C3C);
  endtask

  task automatic t_prefix();
    logic [31:0] expd [4];
    expd[0] = 32'h0; expd[1] = 32'h0; expd[2] = 32'hCAFE_0123; expd[3] = 32'h0A0B_0C0D;
    pkt_mode = 0; pfx_start = 1; step(); pfx_start = 0;
    chk("R11 mode off", 64'(pfx_tvalid), 64'd0);
    pkt_mode = 1; pfx_tready = 1; time_now = 64'h0A0B_0C0D_CAFE_0123;
    pfx_start = 1; step(); pfx_start = 0;
    for (int b = 0; b < 4; b++) begin
      chk("R9 tvalid", 64'(pfx_tvalid), 64'd1);
      chk("R9 tdata", 64'(pfx_tdata), 64'(expd[b]));
      chk("R9 tlast", 64'(pfx_tlast), 64'(b == 3));
      step();
    end
    chk("R9 end", 64'(pfx_tvalid), 64'd0);
    chk("R9 byte order", 64'(expd[2][7:0]), 64'h23);
    // second prefix with a stall on beat 2 and a start pulse mid-stream
    time_now = 64'h5555_6666_7777_8888; pfx_start = 1; step(); pfx_start = 0;
    time_now = 64'h1;
    step(); step();
    pfx_tready = 0; pfx_start = 1; step(); pfx_start = 0;
    chk("R10 stalled valid", 64'(pfx_tvalid), 64'd1);
    chk("R10 stalled data", 64'(pfx_tdata), 64'h7777_8888);
    step(); step();
    chk("R10 still held", 64'(pfx_tdata), 64'h7777_8888);
    chk("R11 restart ignored", 64'(pfx_tlast), 64'd0);
    pfx_tready = 1; step();
    chk("R10 advance", 64'(pfx_tdata), 64'h5555_6666);
    chk("R10 last", 64'(pfx_tlast), 64'd1);
    step();
    chk("R11 no extra prefix", 64'(pfx_tvalid), 64'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; time_now = '0;
    tx_en = 0; tx_strobe = 0; tx_hi_rd = 0; tx_miss_clr = 0;
    rx_en = 0; rx_strobe = 0; rx_hi_rd = 0; rx_miss_clr = 0;
    pkt_mode = 0; pfx_start = 0; pfx_tready = 0;
    step(); step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_capture();
    t_hold();
    t_release();
    t_collide();
    t_miss_race();
    t_disable();
    t_indep();
    t_prefix();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule